// File: doc/BRIEF.md
# MSI Receiver Interrupt Aggregator

This block collects message-signalled interrupt events and turns them into a single level-sensitive interrupt line for a host interrupt controller. Each event arrives as a one-cycle pulse with a vector number. It stands in for an inbound MSI write that has already been decoded. An accepted event sets a sticky status bit for its vector. The output line stays high while any latched vector is both enabled and unmasked.

Enable and mask are separate controls with different effects. A vector that is not enabled ignores its events completely. A vector that is enabled but masked still records its events in status, but it does not drive the output. Clearing the mask therefore raises the output at once, with no new event needed.

Software reaches three 32-bit registers through a small register port:
- enable, at byte offset 0x0;
- mask, at byte offset 0x4;
- status, at byte offset 0x8, which is write-one-to-clear.

Reading a register has no side effect. The line drops only when software clears the status bits that hold it up.

Top module: `msi_irq_aggregator`

## Requirements
- R1: After reset the enable, mask and status registers all read zero and `irq_o` is low.
- R2: An event whose vector is enabled sets that vector's status bit on the clock edge that samples it, and the bit stays set afterwards.
- R3: An event for a vector that is enabled but masked (mask bit 1) sets its status bit, while `irq_o` stays low.
- R4: `irq_o` is high exactly when at least one vector has status 1, enable 1 and mask 0, evaluated one clock earlier; with several such vectors it stays high until the last one is cleared.
- R5: Clearing the mask of a vector whose status is already latched raises `irq_o` with no further event.
- R6: An event for a vector whose enable bit is 0 leaves every status bit unchanged.
- R7: Writing status at offset 0x8 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When an event for a vector and a status write with a 1 in that vector's bit fall on the same clock edge, the bit stays set.
- R9: Reading any register changes no state; `irq_o` stays high until the status is explicitly cleared.
- R10: Register offsets are enable 0x0, mask 0x4, status 0x8 (bit n belongs to vector n). Any other offset reads zero and ignores writes.
- R11: `irq_o` is registered and changes one clock after the status, enable or mask change that causes it.
- R12: An event whose vector index is 32 or higher is dropped and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid_i | input | 1 | One-cycle event strobe |
| evt_idx_i | input | IDX_W (6) | Vector number of the event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (4) | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The assertions assume three things about the inputs:
- `evt_valid_i` is a single-cycle strobe;
- the event index and register inputs are known (not X) whenever the strobes are high;
- inputs change only away from the rising clock edge.

The stimulus keeps within these limits. It drives every input on the falling edge and returns each strobe to zero after one cycle. It never leaves an index or address undriven. Same-cycle collisions between an event and a status clear are produced on purpose, so that the set-over-clear rule is covered both by the assertion and by a port-level check.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFF_EN   = 32'h0;
  localparam int unsigned OFF_MASK = 32'h4;
  localparam int unsigned OFF_STS  = 32'h8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_MASK = 2'd2,
    SEL_STS  = 2'd3
  } reg_sel_e;

  // Map a byte offset onto the register it addresses.
  function automatic reg_sel_e decode_addr(input logic [31:0] addr);
    if (addr == OFF_EN)        return SEL_EN;
    else if (addr == OFF_MASK) return SEL_MASK;
    else if (addr == OFF_STS)  return SEL_STS;
    else                       return SEL_NONE;
  endfunction
endpackage

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned IDX_W   = 6
) (
  input  logic               evt_valid,
  input  logic [IDX_W-1:0]   evt_idx,
  input  logic [NUM_VEC-1:0] en_q,
  output logic [NUM_VEC-1:0] hit
);
  // One comparator per vector. Indices at or beyond NUM_VEC match nothing.
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    assign hit[g] = evt_valid && (evt_idx == IDX_W'(g)) && en_q[g];
  end
endmodule

// File: rtl/msi_reg_file.sv
module msi_reg_file
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_VEC-1:0] status_q,
  output logic [NUM_VEC-1:0] en_q,
  output logic [NUM_VEC-1:0] mask_q,
  output logic [NUM_VEC-1:0] sts_clr,
  output logic [DATA_W-1:0]  rdata
);
  reg_sel_e sel;
  assign sel = decode_addr(32'(addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
    end else if (wr) begin
      if (sel == SEL_EN)   en_q   <= wdata[NUM_VEC-1:0];
      if (sel == SEL_MASK) mask_q <= wdata[NUM_VEC-1:0];
    end
  end

  // Bits to clear in status this cycle (write-one-to-clear).
  assign sts_clr = (wr && sel == SEL_STS) ? wdata[NUM_VEC-1:0] : '0;

  always_comb begin
    unique case (sel)
      SEL_EN:   rdata = DATA_W'(en_q);
      SEL_MASK: rdata = DATA_W'(mask_q);
      SEL_STS:  rdata = DATA_W'(status_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_status_latch.sv
module msi_status_latch #(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] hit,
  input  logic [NUM_VEC-1:0] clr,
  output logic [NUM_VEC-1:0] status_q
);
  // A new event wins over a same-cycle clear of the same bit.
  function automatic logic [NUM_VEC-1:0] next_status(
    input logic [NUM_VEC-1:0] cur,
    input logic [NUM_VEC-1:0] set_v,
    input logic [NUM_VEC-1:0] clr_v
  );
    return (cur & ~clr_v) | set_v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, hit, clr);
  end
endmodule

// File: rtl/msi_irq_out.sv
module msi_irq_out #(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] status_q,
  input  logic [NUM_VEC-1:0] en_q,
  input  logic [NUM_VEC-1:0] mask_q,
  output logic [NUM_VEC-1:0] live,
  output logic               irq_q
);
  function automatic logic [NUM_VEC-1:0] live_vectors(
    input logic [NUM_VEC-1:0] sts,
    input logic [NUM_VEC-1:0] en,
    input logic [NUM_VEC-1:0] msk
  );
    return sts & en & ~msk;
  endfunction

  assign live = live_vectors(status_q, en_q, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live;
  end
endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid_i,
  input  logic [IDX_W-1:0]  evt_idx_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_VEC-1:0] en_q, mask_q, status_q, evt_hit, sts_clr, live;

  msi_vec_decode #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_dec (
    .evt_valid (evt_valid_i),
    .evt_idx   (evt_idx_i),
    .en_q      (en_q),
    .hit       (evt_hit)
  );

  msi_reg_file #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .status_q (status_q),
    .en_q     (en_q),
    .mask_q   (mask_q),
    .sts_clr  (sts_clr),
    .rdata    (reg_rdata_o)
  );

  msi_status_latch #(.NUM_VEC(NUM_VEC)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (evt_hit),
    .clr      (sts_clr),
    .status_q (status_q)
  );

  msi_irq_out #(.NUM_VEC(NUM_VEC)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_q (status_q),
    .en_q     (en_q),
    .mask_q   (mask_q),
    .live     (live),
    .irq_q    (irq_o)
  );
endmodule

// File: rtl/msi_agg_checker.sv
module msi_agg_checker #(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned IDX_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid_i,
  input logic [IDX_W-1:0]   evt_idx_i,
  input logic [NUM_VEC-1:0] evt_hit,
  input logic [NUM_VEC-1:0] sts_clr,
  input logic [NUM_VEC-1:0] status_q,
  input logic [NUM_VEC-1:0] en_q,
  input logic [NUM_VEC-1:0] mask_q,
  input logic               irq_o
);
  AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit != '0) |=> ((status_q & $past(evt_hit)) == $past(evt_hit))); // R2
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_hit & sts_clr) != '0) |=> ((status_q & $past(evt_hit & sts_clr)) != '0)); // R8
  AST_HIT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_hit & ~en_q) == '0) && ($countones(evt_hit) <= 1)); // R6
  AST_BAD_IDX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_i && (32'(evt_idx_i) >= NUM_VEC)) |-> (evt_hit == '0)); // R12
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_hit)) == '0)); // R6
  AST_CLEAR_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(sts_clr)) == '0)); // R7
  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_q & ~mask_q) != '0) |=> irq_o); // R11
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_q & ~mask_q) == '0) |=> !irq_o); // R4
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) == '0) |=> !irq_o); // R3
endmodule

bind msi_irq_aggregator msi_agg_checker #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_valid_i (evt_valid_i),
  .evt_idx_i   (evt_idx_i),
  .evt_hit     (evt_hit),
  .sts_clr     (sts_clr),
  .status_q    (status_q),
  .en_q        (en_q),
  .mask_q      (mask_q),
  .irq_o       (irq_o)
);

// File: tb/msi_irq_aggregator_bench.sv
`timescale 1ns/1ps
module msi_irq_aggregator_bench;
  localparam int IDX_W  = 6;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_EN = 4'h0, A_MSK = 4'h4, A_STS = 4'h8, A_BAD = 4'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [IDX_W-1:0] evt_idx = '0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msi_irq_aggregator u_msi_irq_aggregator (
    .clk (clk), .rst_n (rst_n),
    .evt_valid_i (evt_valid), .evt_idx_i (evt_idx),
    .reg_wr_i (reg_wr), .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata), .irq_o (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evt_valid = 1'b1; evt_idx = IDX_W'(idx);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic pulse_and_clear(input int idx, input logic [31:0] clr);
    @(negedge clk);
    evt_valid = 1'b1; evt_idx = IDX_W'(idx);
    reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = clr;
    @(negedge clk);
    evt_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 enable", A_EN, 32'h0);
    rd_chk("R1 mask", A_MSK, 32'h0);
    rd_chk("R1 status", A_STS, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_basic();
    wr(A_EN, 32'h1);
    pulse(0);
    rd_chk("R2 status set", A_STS, 32'h1);
    chk("R11 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R4 irq high", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    rd_chk("R2 sticky", A_STS, 32'h1);
    rd_chk("R9 read again", A_STS, 32'h1);
    chk("R9 irq held after reads", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h0);
    rd_chk("R7 zero write no effect", A_STS, 32'h1);
    wr(A_STS, 32'h1);
    rd_chk("R7 w1c clears", A_STS, 32'h0);
    chk("R11 irq lags clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R4 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_masked();
    wr(A_EN, 32'h0000_0104);
    wr(A_MSK, 32'h4);
    pulse(2);
    rd_chk("R3 masked latches", A_STS, 32'h4);
    repeat (2) @(negedge clk);
    chk("R3 masked irq low", {31'b0, irq}, 32'h0);
    wr(A_MSK, 32'h0);
    chk("R11 unmask lag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R5 unmask raises irq", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h4);
    @(negedge clk);
    chk("R4 low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_disabled();
    pulse(5);
    rd_chk("R6 disabled ignored", A_STS, 32'h0);
    repeat (2) @(negedge clk);
    chk("R6 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_invalid();
    wr(A_EN, 32'hFFFF_FFFF);
    pulse(32);
    pulse(63);
    rd_chk("R12 out-of-range dropped", A_STS, 32'h0);
    pulse(31);
    rd_chk("R2 top vector", A_STS, 32'h8000_0000);
    wr(A_STS, 32'hFFFF_FFFF);
    rd_chk("R7 clear all", A_STS, 32'h0);
  endtask

  task automatic t_collide();
    wr(A_EN, 32'h18);
    pulse(3);
    pulse_and_clear(3, 32'h8);
    rd_chk("R8 set wins over clear", A_STS, 32'h8);
    pulse_and_clear(4, 32'h8);
    rd_chk("R8 other bit clears", A_STS, 32'h10);
    wr(A_STS, 32'h10);
  endtask

  task automatic t_multi();
    wr(A_EN, 32'h3);
    pulse(0);
    pulse(1);
    @(negedge clk);
    chk("R4 two pending irq", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h1);
    @(negedge clk);
    chk("R4 one left irq high", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h2);
    @(negedge clk);
    chk("R4 none left irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map();
    wr(A_MSK, 32'h0000_A5A5);
    rd_chk("R10 mask readback", A_MSK, 32'h0000_A5A5);
    rd_chk("R10 enable readback", A_EN, 32'h3);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd_chk("R10 bad offset reads zero", A_BAD, 32'h0);
    rd_chk("R10 bad write no enable change", A_EN, 32'h3);
    rd_chk("R10 bad write no mask change", A_MSK, 32'h0000_A5A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_masked();
    t_disabled();
    t_invalid();
    t_collide();
    t_multi();
    t_map();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule